// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the 15-bit effective address that a small 8-bit processor uses for an operand or a branch target. The 32 KB address space is split into four 8 KB pages. The two upper address bits select the page and the lower thirteen bits give the position inside it. Decode logic presents a request with the following inputs:

- the address of the following instruction,
- the two operand bytes,
- the current index register value,
- a mode code,
- a flag that marks branch instructions.

The block returns the address with a one-cycle done strobe. It also returns the index value after any pre-step, so that the register file can write it back.

Direct modes finish one cycle after the request. When the indirect flag is set, the address formed by the mode becomes a pointer location. The block then reads two bytes over a simple read handshake: the high byte first, then the low byte from the next location. It assembles the final address from those two bytes.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset, done, idx_wr and mem_rd are low and ea is zero.
- R2: Mode 0 (relative): ea keeps next_pc[14:13]. Its low 13 bits are next_pc[12:0] plus opnd_lo[6:0], sign-extended from bit 6, modulo 8192. opnd_lo[7] has no effect.
- R3: Mode 1 (zero-page relative): ea is opnd_lo[6:0] sign-extended to 13 bits, with ea[14:13] = 0. The result always lies in 0000h-003Fh or 1FC0h-1FFFh.
- R4: Mode 2 (absolute), and the unused codes 6 and 7: the operand is {opnd_hi[6:0], opnd_lo}, and opnd_hi[7] has no effect. With is_branch high, ea is that 15-bit operand. With is_branch low, ea is {next_pc[14:13], operand[12:0]}.
- R5: Mode 3 (indexed): ea takes its page bits under the rule of R4. Its low 13 bits are operand[12:0] plus idx_in, zero-extended, modulo 8192. idx_out equals idx_in and idx_wr stays low.
- R6: Modes 4 and 5 (indexed with pre-increment or pre-decrement): the index is first stepped by +1 or -1 modulo 256, and the stepped value is used in the sum of R5. idx_out carries the stepped value and idx_wr pulses together with done.
- R7: With indirect high, the address A formed by the mode is a pointer location. The block reads the byte at A, then the byte at (A+1) mod 32768. ea is {first[6:0], second}, and bit 7 of the first byte is ignored.
- R8: mem_rd, once raised, stays high with mem_addr unchanged until mem_rvalid is seen.
- R9: A direct request gives done high in the cycle after req_valid is sampled, and done lasts exactly one cycle. An indirect request gives exactly one done pulse, in the cycle after the second read returns.
- R10: req_valid is ignored while an indirect fetch is in progress. Such a request produces no additional done pulse and does not change ea.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a computation |
| mode | input | 3 | Addressing mode code |
| is_branch | input | 1 | Branch instruction (absolute and indexed may leave the page) |
| indirect | input | 1 | Fetch a pointer from the formed address |
| next_pc | input | 15 | Address of the following instruction |
| opnd_hi | input | 8 | First operand byte |
| opnd_lo | input | 8 | Second operand byte |
| idx_in | input | 8 | Index register value |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 15 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result strobe |
| ea | output | 15 | Effective address |
| idx_out | output | 8 | Index value after pre-step |
| idx_wr | output | 1 | Index write-back strobe |

## Verification
A wrong page select or a wrong sign extension appears in ea on the very next done pulse. The bench therefore sweeps every offset byte, every index value and every high operand byte against sums that it computes itself. A fetch state that advances or sticks wrongly appears within a few cycles: the read address fails to step by one, the done strobe is missing or doubled, or the low and high bytes are swapped in ea. A pointer memory whose contents depend on the address exposes each of these faults.

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
  parameter int ADDR_W = 15,
  parameter int PAGE_W = 13,
  parameter int IDX_W  = 8,
  parameter int OFF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        mode,
  input  logic              is_branch,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [7:0]        opnd_hi,
  input  logic [7:0]        opnd_lo,
  input  logic [IDX_W-1:0]  idx_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [7:0]        mem_rdata,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [IDX_W-1:0]  idx_out,
  output logic              idx_wr
);
  localparam int SEL_W = ADDR_W - PAGE_W;
  localparam logic [2:0] M_REL  = 3'd0;
  localparam logic [2:0] M_ZREL = 3'd1;
  localparam logic [2:0] M_IDX  = 3'd3;
  localparam logic [2:0] M_INC  = 3'd4;
  localparam logic [2:0] M_DEC  = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} st_t;
  st_t st;

  logic [15:0]        opnd_full;
  logic [ADDR_W-1:0]  opnd;
  logic [PAGE_W-1:0]  off_sx;
  logic [IDX_W-1:0]   idx_next;
  logic [PAGE_W-1:0]  idx_ext;
  logic [SEL_W-1:0]   page_sel;
  logic [ADDR_W-1:0]  calc;
  logic               step;
  logic [7:0]         hi_q;
  logic               step_q;

  assign opnd_full = {opnd_hi, opnd_lo};
  assign opnd      = opnd_full[ADDR_W-1:0];
  assign off_sx    = {{(PAGE_W-OFF_W){opnd_lo[OFF_W-1]}}, opnd_lo[OFF_W-1:0]};
  assign idx_ext   = {{(PAGE_W-IDX_W){1'b0}}, idx_next};
  assign page_sel  = is_branch ? opnd[ADDR_W-1:PAGE_W] : next_pc[ADDR_W-1:PAGE_W];
  assign step      = (mode == M_INC) || (mode == M_DEC);

  always_comb begin
    case (mode)
      M_INC:   idx_next = idx_in + 1'b1;
      M_DEC:   idx_next = idx_in - 1'b1;
      default: idx_next = idx_in;
    endcase
  end

  always_comb begin
    case (mode)
      M_REL:                calc = {next_pc[ADDR_W-1:PAGE_W], next_pc[PAGE_W-1:0] + off_sx};
      M_ZREL:               calc = {{SEL_W{1'b0}}, off_sx};
      M_IDX, M_INC, M_DEC:  calc = {page_sel, opnd[PAGE_W-1:0] + idx_ext};
      default:              calc = {page_sel, opnd[PAGE_W-1:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      ea       <= '0;
      idx_out  <= '0;
      idx_wr   <= 1'b0;
      hi_q     <= '0;
      step_q   <= 1'b0;
    end else begin
      done   <= 1'b0;
      idx_wr <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          idx_out <= idx_next;
          step_q  <= step;
          if (indirect) begin
            mem_addr <= calc;
            mem_rd   <= 1'b1;
            st       <= S_HI;
          end else begin
            ea     <= calc;
            done   <= 1'b1;
            idx_wr <= step;
          end
        end
        S_HI: if (mem_rvalid) begin
          hi_q     <= mem_rdata;
          mem_addr <= mem_addr + 1'b1;
          st       <= S_LO;
        end
        S_LO: if (mem_rvalid) begin
          ea     <= {hi_q, mem_rdata}[ADDR_W-1:0];
          mem_rd <= 1'b0;
          done   <= 1'b1;
          idx_wr <= step_q;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr));

  p_lo_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HI) && mem_rvalid |=> mem_addr == $past(mem_addr) + 1'b1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !mem_rd);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> !done || (st == S_IDLE));

  p_wr_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |-> done);

  p_zrel_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) && req_valid && !indirect && (mode == M_ZREL) |=>
      ea[ADDR_W-1:PAGE_W] == '0 && (ea[PAGE_W-1:0] < 13'h0040 || ea[PAGE_W-1:0] >= 13'h1FC0));
endmodule

// File: tb/paged_ea_gen_bench.sv
module paged_ea_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] mode = '0;
  logic is_branch = 1'b0;
  logic indirect = 1'b0;
  logic [14:0] next_pc = '0;
  logic [7:0] opnd_hi = '0, opnd_lo = '0, idx_in = '0;
  logic mem_rd, done, idx_wr;
  logic [14:0] mem_addr, ea;
  logic [7:0] idx_out;
  logic mem_rvalid = 1'b0;
  logic [7:0] mem_rdata = '0;
  int checks = 0, errors = 0, done_cnt = 0;

  always #2.5 clk = ~clk;

  paged_ea_gen u_paged_ea_gen (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .is_branch(is_branch), .indirect(indirect), .next_pc(next_pc),
    .opnd_hi(opnd_hi), .opnd_lo(opnd_lo), .idx_in(idx_in),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .done(done), .ea(ea), .idx_out(idx_out), .idx_wr(idx_wr));

  function automatic logic [7:0] mbyte(input logic [14:0] a);
    int v = a * 37 + (a >> 7) + 11;
    return v[7:0];
  endfunction

  always @(posedge clk) begin
    if (mem_rd && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mbyte(mem_addr);
    end else mem_rvalid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int offs(input logic [7:0] lo);
    return lo[6] ? int'(lo[6:0]) - 128 : int'(lo[6:0]);
  endfunction

  function automatic int calc_exp(input logic [2:0] m, input logic br, input logic [14:0] pc,
                                  input logic [7:0] h, input logic [7:0] l, input logic [7:0] ix);
    int op = (int'(h[6:0]) << 8) | int'(l);
    int pg = br ? (op >> 13) : int'(pc >> 13);
    int ixs = (m == 4) ? ((ix + 1) % 256) : (m == 5) ? ((ix + 255) % 256) : int'(ix);
    case (m)
      3'd0: return int'(pc >> 13) * 8192 + ((int'(pc) % 8192 + offs(l) + 8192) % 8192);
      3'd1: return (offs(l) + 8192) % 8192;
      3'd3, 3'd4, 3'd5: return pg * 8192 + ((op % 8192) + ixs) % 8192;
      default: return pg * 8192 + op % 8192;
    endcase
  endfunction

  task automatic run(input string req, input logic [2:0] m, input logic br, input logic ind,
                     input logic [14:0] pc, input logic [7:0] h, input logic [7:0] l, input logic [7:0] ix);
    int a, e, waited;
    int exp_ix = (m == 4) ? ((ix + 1) % 256) : (m == 5) ? ((ix + 255) % 256) : int'(ix);
    @(negedge clk);
    mode = m; is_branch = br; indirect = ind; next_pc = pc;
    opnd_hi = h; opnd_lo = l; idx_in = ix; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    a = calc_exp(m, br, pc, h, l, ix);
    if (!ind) begin
      chk({req, " R9 latency"}, int'(done), 1);
      e = a;
    end else begin
      waited = 0;
      while (!done && waited < 20) begin @(negedge clk); waited++; end
      chk({req, " R9 indirect done"}, int'(done), 1);
      e = ((int'(mbyte(a[14:0])) & 127) << 8) | int'(mbyte(15'((a + 1) % 32768)));
    end
    chk(req, int'(ea), e);
    chk({req, " R6 idx_out"}, int'(idx_out), exp_ix);
    chk({req, " R6 idx_wr"}, int'(idx_wr), (m == 4 || m == 5) ? 1 : 0);
    @(negedge clk);
    chk({req, " R9 pulse width"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", int'(done), 0);
    chk("R1 mem_rd", int'(mem_rd), 0);
    chk("R1 idx_wr", int'(idx_wr), 0);
    chk("R1 ea", int'(ea), 0);
    rst_n = 1'b1;

    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 256; l++)
        run("R2 relative", 3'd0, p[0], 1'b0, 15'(p * 8192 + (p == 1 ? 20 : p == 2 ? 8170 : 4000)), 8'h00, 8'(l), 8'h00);
    for (int l = 0; l < 256; l++)
      run("R3 zero-page", 3'd1, 1'b0, 1'b0, 15'h5123, 8'h00, 8'(l), 8'h00);
    for (int h = 0; h < 256; h++)
      for (int b = 0; b < 2; b++) begin
        run("R4 absolute", 3'd2, b[0], 1'b0, 15'h4ABC, 8'(h), 8'h5A, 8'h00);
        run("R4 spare code", (h % 2) ? 3'd6 : 3'd7, b[0], 1'b0, 15'h2001, 8'(h), 8'hC3, 8'h00);
      end
    for (int m = 3; m < 6; m++)
      for (int x = 0; x < 256; x++)
        for (int b = 0; b < 2; b++)
          run(m == 3 ? "R5 indexed" : "R6 stepped index", 3'(m), b[0], 1'b0, 15'h6010, 8'hBF, 8'hA0, 8'(x));
    for (int k = 0; k < 48; k++)
      run("R7 indirect", 3'(k % 6), k[2], 1'b1, 15'(k * 683 + 7), 8'(k * 29), 8'(k * 53 + 1), 8'(k * 11));
    run("R7 pointer wrap", 3'd2, 1'b1, 1'b1, 15'h0000, 8'h7F, 8'hFF, 8'h00);

    @(negedge clk);
    done_cnt = 0;
    mode = 3'd2; is_branch = 1'b1; indirect = 1'b1; next_pc = '0;
    opnd_hi = 8'h12; opnd_lo = 8'h34; req_valid = 1'b1;
    @(negedge clk);
    chk("R8 mem_rd raised", int'(mem_rd), 1);
    mode = 3'd1; indirect = 1'b0; opnd_lo = 8'h05;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 single done", done_cnt, 1);
    chk("R10 ea from pointer", int'(ea),
        ((int'(mbyte(15'h1234)) & 127) << 8) | int'(mbyte(15'h1235)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule